// File: doc/BRIEF.md
# Multi-Mode Test Register

This block is a W-bit register whose behaviour is picked by two mode bits. It can serve as a plain parallel register in the functional path, or as a serial scan chain that loads and unloads test state. It can also produce pseudorandom stimulus from a linear feedback shift register, or compact a stream of parallel responses into a signature. One register can therefore stimulate the logic on one side of it and observe the logic on the other side across successive test phases, without extra flip-flops.

Stage 0 is the entry stage and stage W-1 is the last stage; every shifting mode moves data from stage i to stage i+1. The feedback bit is the XOR of the stages selected by a tap mask. The default width of 8 uses the primitive polynomial x^8+x^6+x^5+x^4+1, so the taps are stages 7, 5, 4 and 3. Reset loads a nonzero seed, so the generator can run as soon as reset is released.

Top module: `obs_test_reg`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released, par_out equals SEED (default 1) and scan_out equals SEED[W-1].
- R2: With {mode_b1,mode_b2} = 2'b00 (scan), each clock loads par_out with {par_out[W-2:0], scan_in}.
- R3: With {mode_b1,mode_b2} = 2'b01 (generator) and a nonzero state, each clock loads {par_out[W-2:0], fb}. fb is the XOR of par_out[i] over every i set in TAPS (default 8'hB8). par_in has no effect in this mode.
- R4: With {mode_b1,mode_b2} = 2'b10 (normal), each clock loads par_out with par_in.
- R5: With {mode_b1,mode_b2} = 2'b11 (signature), each clock loads {par_out[W-2:0], fb} XOR par_in, with fb as in R3.
- R6: In generator mode an all-zero state is replaced by SEED on the next clock, so the generator never stays stuck at zero.
- R7: Starting from SEED in generator mode with the default polynomial, the register visits 255 distinct nonzero states and returns to SEED after exactly 255 clocks.
- R8: scan_out always equals par_out[W-1], in every mode.
- R9: scan_in has no effect in generator, normal and signature modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, loads SEED |
| mode_b1 | input | 1 | Upper mode bit |
| mode_b2 | input | 1 | Lower mode bit |
| par_in | input | W | Parallel data input (normal and signature modes) |
| scan_in | input | 1 | Serial input to stage 0 (scan mode) |
| par_out | output | W | Register state |
| scan_out | output | 1 | Value of the last stage |

## Verification
All the state of the block appears on par_out, so a wrong stage value, a wrong tap or a wrong mode decode shows at the ports on the clock edge right after it happens. The bench runs a cycle-by-cycle model and compares its state with par_out and scan_out on every cycle. Any divergence is therefore reported within one cycle, never only at the end of a signature run. For the generator, the bench also checks that the sequence is distinct and that its period is exactly 255. This catches a tap error that still gives a plausible-looking next state.

// File: rtl/obs_pkg.sv
package obs_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN = 2'b00,
        MODE_GEN  = 2'b01,
        MODE_LOAD = 2'b10,
        MODE_SIG  = 2'b11
    } obs_mode_e;

    function automatic obs_mode_e decode_mode(input logic b1, input logic b2);
        return obs_mode_e'({b1, b2});
    endfunction

endpackage

// File: rtl/obs_feedback.sv
module obs_feedback #(
    parameter int unsigned        W    = 8,
    parameter logic [W-1:0]       TAPS = 8'hB8
) (
    input  logic [W-1:0] cur,
    output logic         fb
);
    logic [W:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (TAPS[i]) begin : g_on
            assign acc[i+1] = acc[i] ^ cur[i];
        end else begin : g_off
            assign acc[i+1] = acc[i];
        end
    end

    assign fb = acc[W];
endmodule

// File: rtl/obs_nextstate.sv
module obs_nextstate
    import obs_pkg::*;
#(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  obs_mode_e    mode,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] par_in,
    input  logic         scan_in,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ZERO = '0;

    logic         fb;
    logic [W-1:0] shifted_scan;
    logic [W-1:0] shifted_fb;
    logic         is_zero;

    obs_feedback #(.W(W), .TAPS(TAPS)) u_fb (
        .cur (cur),
        .fb  (fb)
    );

    assign shifted_scan = {cur[W-2:0], scan_in};
    assign shifted_fb   = {cur[W-2:0], fb};
    assign is_zero      = (cur == ZERO);

    always_comb begin
        nxt = cur;
        unique case (mode)
            MODE_SCAN: nxt = shifted_scan;
            MODE_GEN:  nxt = is_zero ? SEED : shifted_fb;
            MODE_LOAD: nxt = par_in;
            MODE_SIG:  nxt = shifted_fb ^ par_in;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/obs_test_reg.sv
module obs_test_reg
    import obs_pkg::*;
#(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_b1,
    input  logic         mode_b2,
    input  logic [W-1:0] par_in,
    input  logic         scan_in,
    output logic [W-1:0] par_out,
    output logic         scan_out
);
    typedef struct packed {
        logic [W-1:0] stages;
    } reg_state_t;

    reg_state_t st_d, st_q;
    obs_mode_e  mode;
    logic [W-1:0] nxt;

    assign mode = decode_mode(mode_b1, mode_b2);

    obs_nextstate #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_next (
        .mode    (mode),
        .cur     (st_q.stages),
        .par_in  (par_in),
        .scan_in (scan_in),
        .nxt     (nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.stages = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stages <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_out  = st_q.stages;
    assign scan_out = st_q.stages[W-1];
endmodule

// File: rtl/obs_test_reg_chk.sv
module obs_test_reg_chk
    import obs_pkg::*;
#(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_b1,
    input logic         mode_b2,
    input logic [W-1:0] par_in,
    input logic         scan_in,
    input logic [W-1:0] par_out,
    input logic         scan_out
);
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    logic [1:0] m;
    assign m = {mode_b1, mode_b2};

    assert_reset_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> par_out == SEED);

    assert_scan_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(m) == 2'b00) |->
        par_out == {$past(par_out[W-2:0]), $past(scan_in)});

    assert_gen_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(m) == 2'b01 && $past(par_out) != '0) |->
        par_out == {$past(par_out[W-2:0]), ^($past(par_out) & TAPS)});

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(m) == 2'b10) |-> par_out == $past(par_in));

    assert_sig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(m) == 2'b11) |->
        par_out == ({$past(par_out[W-2:0]), ^($past(par_out) & TAPS)} ^ $past(par_in)));

    assert_zero_escape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(m) == 2'b01 && $past(par_out) == '0) |-> par_out == SEED);
endmodule

bind obs_test_reg obs_test_reg_chk #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_b1  (mode_b1),
    .mode_b2  (mode_b2),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .par_out  (par_out),
    .scan_out (scan_out)
);

// File: tb/sim_obs_test_reg.sv
module sim_obs_test_reg;
    localparam int  W      = 8;
    localparam int  TAPS   = 'hB8;
    localparam int  SEED   = 1;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_b1 = 1'b0;
    logic         mode_b2 = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] par_out;
    logic         scan_out;

    int n_chk = 0;
    int n_fail = 0;
    int expv = SEED;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    obs_test_reg u0 (
        .clk(clk), .rst_n(rst_n), .mode_b1(mode_b1), .mode_b2(mode_b2),
        .par_in(par_in), .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
    );

    function automatic int parity_of(int v);
        int c = 0;
        for (int i = 0; i < W; i++) if ((v >> i) & 1) c++;
        return c % 2;
    endfunction

    function automatic int model_next(int s, int m, int pin, int si);
        int sh = (s << 1) & ((1 << W) - 1);
        int fb = parity_of(s & TAPS);
        case (m)
            0: return sh | si;
            1: return (s == 0) ? SEED : (sh | fb);
            2: return pin;
            default: return (sh | fb) ^ pin;
        endcase
    endfunction

    task automatic check(string req, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic string tag_of(int m);
        case (m)
            0: return "R2";
            1: return "R3/R9";
            2: return "R4/R9";
            default: return "R5/R9";
        endcase
    endfunction

    // one clock with given inputs; compares par_out and scan_out after the edge
    task automatic tick(int m, int pin, int si, string tag = "");
        mode_b1 = m[1];
        mode_b2 = m[0];
        par_in  = pin[W-1:0];
        scan_in = si[0];
        @(posedge clk);
        expv = model_next(expv, m, pin, si);
        #(PERIOD/4);
        check((tag == "") ? tag_of(m) : tag, int'(par_out), expv);
        check("R8", int'(scan_out), (expv >> (W-1)) & 1);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        end
        $finish;
    end

    initial begin
        int first;
        bit seen [0:255];
        int period;
        // R1: reset state
        #(PERIOD * 2 + PERIOD/4);
        check("R1", int'(par_out), SEED);
        check("R1", int'(scan_out), (SEED >> (W-1)) & 1);
        @(negedge clk);
        rst_n = 1'b1;
        expv = SEED;
        // R1: first edge after release holds seed in normal mode loading SEED? use generator-free check
        tick(0, 'h00, 1);
        // R2: shift a pattern in
        for (int i = 0; i < 8; i++) tick(0, 'hFF, (8'hA5 >> i) & 1);
        // R4: parallel loads, with scan_in toggling (R9)
        tick(2, 'h3C, 1);
        tick(2, 'hC3, 0);
        tick(2, 'h80, 1);
        // R3 / R9: generator with par_in and scan_in noise
        for (int i = 0; i < 20; i++) tick(1, i * 37, i & 1);
        // R5: signature compaction
        for (int i = 0; i < 16; i++) tick(3, (i * 91 + 5) & 255, (i >> 1) & 1);
        // R6: zero state in generator mode escapes to seed
        tick(2, 'h00, 0);
        tick(1, 'h55, 1, "R6");
        tick(1, 'h00, 0, "R6");
        // R7: full period from seed
        tick(2, SEED, 0);
        for (int i = 0; i < 256; i++) seen[i] = 0;
        first = int'(par_out);
        seen[first] = 1;
        period = 0;
        for (int i = 0; i < 255; i++) begin
            tick(1, 0, 0, "R3");
            period++;
            if (int'(par_out) == first) break;
            if (par_out == '0 || seen[int'(par_out)]) begin
                check("R7", int'(par_out), -1);
            end
            seen[int'(par_out)] = 1;
        end
        check("R7", period, 255);
        check("R7", int'(par_out), SEED);
        // mid-run reset returns to seed (R1)
        @(negedge clk);
        rst_n = 1'b0;
        #(PERIOD/4);
        check("R1", int'(par_out), SEED);
        @(negedge clk);
        rst_n = 1'b1;
        expv = SEED;
        tick(3, 'h0F, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule